// File: doc/BRIEF.md
# Seven-Level Staircase Gate Pattern Generator

This block drives the switches of one phase of a cascaded inverter built from three full bridges. Each bridge can put +1, 0 or −1 units of its dc source on the output. The series sum gives a seven-step staircase at the fundamental frequency. Every switch changes state only twice per period. The fundamental period is divided into 1000 positions, and the position advances by one on each single-cycle update strobe. Three switching angles, given as positions within the first quarter period, set where each bridge's pulse begins. The pulse is mirrored about the half and full period.

Each bridge has two legs. Each leg is high for exactly half a period. Leg A rises at the bridge angle. Leg B rises at half a period minus that angle. The amount by which the two legs are out of step sets the width of the quasi-square pulse. A sequencer with three named states controls operation. In ST_IDLE the gates sit in the zero state and the position is held at 0. In ST_RUN the staircase is produced. In ST_FAULT the angle set broke the ordering rule, so the gates are parked and an error flag is shown. Angles are captured only at a period boundary, so a change made mid-period cannot cut a pulse short.

The transitions are as follows:
- IDLE→RUN or IDLE→FAULT happens on the first strobe while enabled.
- RUN→FAULT, FAULT→RUN, RUN→RUN and FAULT→FAULT happen at the wrap strobe, chosen by the newly captured angles.
- RUN→IDLE and FAULT→IDLE happen whenever enable is low.

Top module: `stair_gate_gen`

## Requirements
- R1: After reset the block is in ST_IDLE. Every bridge field of `gates_o` reads 4'b1010 (zero state), `level_o` is 0 and `fault_o` is 0.
- R2: Bridge k owns `gates_o[4k+3:4k]`, laid out as {S4,S3,S2,S1}. S1 is leg A and S3 is leg B. S2 is the inverse of S1 and S4 is the inverse of S3.
- R3: In ST_RUN, with position p and captured angle t of bridge k, leg A is high when t ≤ p < t+500. Leg B is high when 500−t ≤ p < 1000−t.
- R4: `level_o` is a 3-bit two's-complement value equal to the sum over all bridges of (legA − legB). It stays within −3..+3.
- R5: In ST_RUN or ST_FAULT, each strobe on `tick_i` advances the position by one and wraps from 999 to 0. Without a strobe the outputs hold.
- R6: In ST_IDLE with `enable_i` high, a strobe captures the angles and sets the position to 0. The block then enters ST_RUN, and the outputs show position 0 right after that edge.
- R7: Angles on `angles_i` are captured only at the start strobe or the wrap strobe. Changes at any other time have no effect until the next wrap.
- R8: A captured set that is not strictly ascending (θ1<θ2<θ3), or whose θ3 exceeds 250, sends the block to ST_FAULT. There `fault_o`=1, all bridges are in the zero state and `level_o`=0. The position keeps counting, and the next wrap re-evaluates the captured set.
- R9: With `enable_i` low, the block enters ST_IDLE on the next clock edge with the position at 0. If a strobe arrives in the same cycle, `enable_i` takes priority.
- R10: `angles_i[10k+9:10k]` holds the angle of bridge k, where bridge 0 takes θ1. The angle values 0 and 250 are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request; low forces idle |
| tick_i | input | 1 | Single-cycle position strobe |
| angles_i | input | 30 | Three 10-bit angle positions, bridge 0 in the low bits |
| gates_o | output | 12 | Four switch bits per bridge |
| level_o | output | 3 | Signed staircase level |
| fault_o | output | 1 | Captured angle set is illegal |

## Verification
Two events can land in the same cycle. The first pair is the wrap strobe and a change of angle inputs. The bench changes the angles mid-period and expects the old pulse edges until the wrap. It then expects the new edges from position 0 onward. The second pair is a strobe and enable falling together. The bench raises both in one cycle and expects the idle zero state, not an advanced position. A restart must then begin at position 0.

// File: rtl/stair_pkg.sv
package stair_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } stair_state_e;

    // Per-bridge switch word {S4,S3,S2,S1} with both legs low
    localparam logic [3:0] BRIDGE_ZERO = 4'b1010;

endpackage

// File: rtl/stair_order_chk.sv
module stair_order_chk #(
    parameter int NB = 3,
    parameter int AW = 10,
    parameter int QUARTER = 250
) (
    input  logic [NB*AW-1:0] angles_i,
    output logic             ok_o
);
    localparam logic [AW-1:0] QMAX = AW'(QUARTER);

    always_comb begin
        ok_o = (angles_i[NB*AW-1 -: AW] <= QMAX);
        for (int i = 0; i < NB - 1; i++) begin
            if (angles_i[i*AW +: AW] >= angles_i[(i+1)*AW +: AW]) begin
                ok_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/stair_seq.sv
module stair_seq
    import stair_pkg::*;
#(
    parameter int NB = 3,
    parameter int PERIOD = 1000,
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [NB*AW-1:0] angles_i,
    input  logic             ok_i,
    output stair_state_e     state_o,
    output logic [AW-1:0]    pos_o,
    output logic [NB*AW-1:0] shadow_o
);
    localparam logic [AW-1:0] LAST = AW'(PERIOD - 1);

    stair_state_e     state_q, state_d;
    logic [AW-1:0]    pos_q, pos_d;
    logic [NB*AW-1:0] shadow_q;
    logic             boundary;

    assign boundary = tick_i && ((state_q == ST_IDLE) || (pos_q == LAST));

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                pos_d = '0;
                if (enable_i && tick_i) state_d = ok_i ? ST_RUN : ST_FAULT;
            end
            ST_RUN, ST_FAULT: begin
                if (!enable_i) begin
                    state_d = ST_IDLE;
                    pos_d   = '0;
                end else if (tick_i) begin
                    pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
                    if (boundary) state_d = ok_i ? ST_RUN : ST_FAULT;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pos_q    <= '0;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            if (enable_i && boundary) shadow_q <= angles_i;
        end
    end

    assign state_o  = state_q;
    assign pos_o    = pos_q;
    assign shadow_o = shadow_q;

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);  // R5
    AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pos_q == '0));  // R9
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && enable_i && tick_i && pos_q == LAST) |=> (pos_q == '0));  // R5
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && enable_i && !tick_i) |=> $stable(pos_q));  // R5
    AST_ANGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !(tick_i && pos_q == LAST)) |=> $stable(shadow_q));  // R7
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_IDLE));  // R9
endmodule

// File: rtl/stair_bridge.sv
module stair_bridge #(
    parameter int PERIOD = 1000,
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     pos_i,
    input  logic [AW-1:0]     theta_i,
    input  logic              active_i,
    output logic [3:0]        gate_o,
    output logic signed [1:0] lvl_o
);
    localparam logic [AW-1:0] HALF = AW'(PERIOD / 2);
    localparam logic [AW-1:0] FULL = AW'(PERIOD);

    logic leg_a, leg_b;

    always_comb begin
        leg_a = active_i && (pos_i >= theta_i) && (pos_i < theta_i + HALF);
        leg_b = active_i && (pos_i >= HALF - theta_i) && (pos_i < FULL - theta_i);
        gate_o = {~leg_b, leg_b, ~leg_a, leg_a};
        if (leg_a && !leg_b)      lvl_o = 2'sb01;
        else if (!leg_a && leg_b) lvl_o = 2'sb11;
        else                      lvl_o = 2'sb00;
    end

    AST_POS_HALF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o == 2'sb01) |-> (pos_i < HALF));  // R3
    AST_NEG_HALF_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o == 2'sb11) |-> (pos_i >= HALF));  // R3
endmodule

// File: rtl/stair_gate_gen.sv
module stair_gate_gen
    import stair_pkg::*;
#(
    parameter int NB = 3,
    parameter int PERIOD = 1000,
    localparam int AW = $clog2(PERIOD),
    localparam int LW = $clog2(NB + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 tick_i,
    input  logic [NB*AW-1:0]     angles_i,
    output logic [NB*4-1:0]      gates_o,
    output logic signed [LW-1:0] level_o,
    output logic                 fault_o
);
    localparam int QUARTER = PERIOD / 4;

    stair_state_e     state;
    logic [AW-1:0]    pos;
    logic [NB*AW-1:0] shadow;
    logic             angles_ok;
    logic             active;
    logic [NB*4-1:0]  gate_w;
    logic signed [1:0] lvl_w [NB];

    stair_order_chk #(.NB(NB), .AW(AW), .QUARTER(QUARTER)) u_chk (
        .angles_i (angles_i),
        .ok_o     (angles_ok)
    );

    stair_seq #(.NB(NB), .PERIOD(PERIOD), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .tick_i   (tick_i),
        .angles_i (angles_i),
        .ok_i     (angles_ok),
        .state_o  (state),
        .pos_o    (pos),
        .shadow_o (shadow)
    );

    assign active = (state == ST_RUN);

    for (genvar k = 0; k < NB; k++) begin : g_bridge
        stair_bridge #(.PERIOD(PERIOD), .AW(AW)) u_br (
            .clk      (clk),
            .rst_n    (rst_n),
            .pos_i    (pos),
            .theta_i  (shadow[k*AW +: AW]),
            .active_i (active),
            .gate_o   (gate_w[k*4 +: 4]),
            .lvl_o    (lvl_w[k])
        );
    end

    always_comb begin
        gates_o = gate_w;
        fault_o = (state == ST_FAULT);
        level_o = '0;
        for (int k = 0; k < NB; k++) begin
            level_o = level_o + {{(LW-2){lvl_w[k][1]}}, lvl_w[k]};
        end
    end

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (level_o == '0 && gates_o == {NB{BRIDGE_ZERO}}));  // R8
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o <= LW'(NB)) && (level_o >= -LW'(NB)));  // R4
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (gates_o == {NB{BRIDGE_ZERO}}));  // R1
endmodule

// File: tb/stair_gate_gen_tb.sv
`timescale 1ns/1ps
module stair_gate_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [29:0] angles_i = '0;
    logic [11:0] gates_o;
    logic signed [2:0] level_o;
    logic        fault_o;

    int n_checks = 0;
    int n_errors = 0;

    // behavioural model state
    int  mpos = 0;
    int  ma[3] = '{0, 0, 0};
    bit  midle = 1'b1;
    bit  mfault = 1'b0;

    always #2 clk = ~clk;

    stair_gate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .tick_i(tick_i),
        .angles_i(angles_i), .gates_o(gates_o), .level_o(level_o), .fault_o(fault_o)
    );

    function automatic bit legal(int a0, int a1, int a2);
        return (a0 < a1) && (a1 < a2) && (a2 <= 250);
    endfunction

    task automatic set_angles(int a0, int a1, int a2);
        angles_i = {10'(a2), 10'(a1), 10'(a0)};
    endtask

    task automatic capture();
        ma[0] = int'(angles_i[9:0]);
        ma[1] = int'(angles_i[19:10]);
        ma[2] = int'(angles_i[29:20]);
        mfault = !legal(ma[0], ma[1], ma[2]);
    endtask

    task automatic check_out(string req);
        logic [11:0] eg;
        int el;
        bit run;
        eg = '0;
        el = 0;
        run = !midle && !mfault;
        for (int k = 0; k < 3; k++) begin
            bit a, b;
            a = run && (mpos >= ma[k]) && (mpos < ma[k] + 500);
            b = run && (mpos >= 500 - ma[k]) && (mpos < 1000 - ma[k]);
            eg[k*4 +: 4] = {~b, b, ~a, a};
            el += int'(a) - int'(b);
        end
        n_checks++;
        if (gates_o !== eg || int'(level_o) != el || fault_o !== (mfault && !midle)) begin
            n_errors++;
            $display("FAIL %s pos=%0d: gates=%b level=%0d fault=%b expected gates=%b level=%0d fault=%b",
                     req, mpos, gates_o, level_o, fault_o, eg, el, mfault && !midle);
        end
    endtask

    // one strobe, model update, check
    task automatic tick_once(string req);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        if (!enable_i) begin
            midle = 1'b1; mpos = 0;
        end else if (midle) begin
            midle = 1'b0; mpos = 0; capture();
        end else if (mpos == 999) begin
            mpos = 0; capture();
        end else begin
            mpos++;
        end
        check_out(req);
    endtask

    task automatic stop_run();
        enable_i = 1'b0;
        @(negedge clk);
        midle = 1'b1; mpos = 0; mfault = 1'b0;
        enable_i = 1'b1;
    endtask

    task automatic t_reset();
        check_out("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1");
        if (gates_o !== 12'b1010_1010_1010) begin
            n_errors++;
            $display("FAIL R1: gates=%b expected %b", gates_o, 12'b1010_1010_1010);
        end
        n_checks++;
    endtask

    task automatic t_staircase(int a0, int a1, int a2);
        stop_run();
        set_angles(a0, a1, a2);
        tick_once("R6");
        for (int i = 0; i < 1000; i++) tick_once("R3 R4 R2 R5 R10");
        if (mpos != 0) $display("bench model out of step");
    endtask

    task automatic t_no_tick();
        for (int i = 0; i < 137; i++) tick_once("R3");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_out("R5 hold");
        end
        tick_once("R5");
    endtask

    task automatic t_midperiod_change();
        stop_run();
        set_angles(30, 60, 90);
        tick_once("R6");
        for (int i = 0; i < 400; i++) tick_once("R3");
        set_angles(10, 20, 30);
        for (int i = 0; i < 599; i++) tick_once("R7 old angles");
        tick_once("R7 wrap capture");
        for (int i = 0; i < 300; i++) tick_once("R7 new angles");
    endtask

    task automatic t_fault();
        stop_run();
        set_angles(100, 50, 200);
        tick_once("R8");
        for (int i = 0; i < 998; i++) tick_once("R8 parked");
        set_angles(20, 50, 110);
        tick_once("R8 still captured");
        tick_once("R8 recover at wrap");
        for (int i = 0; i < 200; i++) tick_once("R8 run after");
        stop_run();
        set_angles(0, 250, 251);
        tick_once("R8 theta3 over quarter");
        for (int i = 0; i < 10; i++) tick_once("R8");
        stop_run();
        set_angles(40, 40, 200);
        tick_once("R8 equal angles");
        for (int i = 0; i < 10; i++) tick_once("R8");
    endtask

    task automatic t_enable_drop();
        stop_run();
        set_angles(15, 70, 140);
        tick_once("R6");
        for (int i = 0; i < 123; i++) tick_once("R3");
        enable_i = 1'b0;
        tick_once("R9 enable beats strobe");
        @(negedge clk);
        check_out("R9 idle");
        enable_i = 1'b1;
        tick_once("R9 restart at zero");
        for (int i = 0; i < 200; i++) tick_once("R3");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        t_reset();
        enable_i = 1'b1;
        t_staircase(0, 1, 250);
        t_staircase(12, 57, 154);
        t_no_tick();
        t_midperiod_change();
        t_fault();
        t_enable_drop();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule